// File: doc/BRIEF.md
# Multicycle Eight-Opcode Processor Core

This block is a small processor core that runs one instruction at a time through a fixed sequence of steps: fetch, decode, execute, an optional memory step and an optional register write-back. Instructions are 25 bits wide with a 3-bit opcode. The core has eight 32-bit general registers and a single word-addressed memory that holds both program and data, reached through one synchronous port. Read data returns on the cycle after the address is presented, and a write takes effect at the clock edge where the write strobe is high.

The instruction set covers two register-to-register operations (add and bitwise not-and), a word load, a word store, a branch on equal registers with a signed offset relative to the next instruction, a no-op and a halt. After a halt the core raises `halted` and freezes its program counter and registers until the next reset. A debug port shows the program counter and any register chosen by a select input, so a bench or a monitor can see the machine state without disturbing it.

Top module: `mc8_core`

## Requirements
- R1: While `rst` is high and after it falls, the PC is 0, `halted` is 0, `mem_we` is 0 and all eight registers read as 0.
- R2: Field layout: opcode in bits 24..22, first source register in 21..19, second register in 18..16, destination register in 2..0 and a 16-bit two's-complement offset in 15..0; opcode values are add 0, nand 1, lw 2, sw 3, beq 4, halt 6, noop 7, and code 5 acts as a no-op.
- R3: add writes regA + regB, wrapping modulo 2^32, into the destination register; bits 15..3 have no effect.
- R4: nand writes the bitwise inverse of (regA AND regB) into the destination register.
- R5: lw writes memory word at (regA + sign-extended offset, low 16 bits as address) into regB.
- R6: sw writes regB to memory at (regA + sign-extended offset); `mem_we` is high for exactly one cycle per store and never for any other instruction.
- R7: beq sets PC to PC + 1 + offset when regA equals regB, including negative offsets, and to PC + 1 otherwise.
- R8: noop and opcode 5 change no register and no memory word, whatever bits 21..0 hold.
- R9: halt raises `halted`; from then on the PC and every register stay unchanged until reset.
- R10: `dbg_reg_data` shows the register chosen by `dbg_reg_sel` one clock after the select is applied; `dbg_pc` shows the current PC.
- R11: Every instruction other than a taken branch or a halt advances the PC by exactly one, and each fetch presents the PC on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | PC_W | Word address for fetch, load or store |
| mem_we | output | 1 | Write strobe for a store |
| mem_wdata | output | XLEN | Data to store |
| mem_rdata | input | XLEN | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt has executed |
| dbg_pc | output | PC_W | Current program counter |
| dbg_reg_sel | input | 3 | Register index to observe |
| dbg_reg_data | output | XLEN | Value of the selected register, one cycle late |

## Verification
A countdown loop with a backward branch shows that taken and fall-through branches, loads through a non-zero base and add all combine correctly over many iterations, and that the machine stops at the halt address. Arithmetic patterns with all-ones operands separate a correct wrap-around add and a true not-and from a plain AND or OR, and set the unused bits of the R-type word to tell correct field slicing from a shifted decode. Store tests with positive and negative offsets, read back through a load, show the effective address and the one-cycle write strobe, while no-op words filled with ones in every free bit show that nothing is written. A freeze test watches the PC and registers for many cycles after halt, and a reset after a run shows that the registers clear.

// File: rtl/mc8_pkg.sv
`timescale 1ns/1ps
package mc8_pkg;

  localparam int INSTR_W  = 25;
  localparam int OP_LSB   = 22;
  localparam int RA_LSB   = 19;
  localparam int RB_LSB   = 16;
  localparam int RD_LSB   = 0;
  localparam int RIDX_W   = 3;
  localparam int OFF_W    = 16;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_RSV  = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEM,
    ST_WB,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic alu_nand;
    logic wr_rd;
    logic is_lw;
    logic is_sw;
    logic is_beq;
    logic is_halt;
  } ctl_t;

endpackage

// File: rtl/mc8_regfile.sv
`timescale 1ns/1ps
module mc8_regfile #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);
  localparam int N = 1 << AW;

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];

  // R3 R5: a write lands in the addressed register on the next cycle
  wr_land_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/mc8_alu.sv
`timescale 1ns/1ps
module mc8_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         nand_sel,
  output logic [W-1:0] res,
  output logic         same
);
  always_comb begin
    if (nand_sel) res = ~(opa & opb);
    else          res = opa + opb;
  end

  assign same = (opa == opb);
endmodule

// File: rtl/mc8_decode.sv
`timescale 1ns/1ps
module mc8_decode
  import mc8_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output logic [RIDX_W-1:0]  idx_a,
  output logic [RIDX_W-1:0]  idx_b,
  output logic [RIDX_W-1:0]  idx_d,
  output logic [OFF_W-1:0]   offset,
  output ctl_t               ctl
);
  opcode_e op;

  assign op     = opcode_e'(word[OP_LSB +: 3]);
  assign idx_a  = word[RA_LSB +: RIDX_W];
  assign idx_b  = word[RB_LSB +: RIDX_W];
  assign idx_d  = word[RD_LSB +: RIDX_W];
  assign offset = word[OFF_W-1:0];

  always_comb begin
    ctl = '0;
    case (op)
      OP_ADD:  ctl.wr_rd = 1'b1;
      OP_NAND: begin ctl.wr_rd = 1'b1; ctl.alu_nand = 1'b1; end
      OP_LW:   ctl.is_lw   = 1'b1;
      OP_SW:   ctl.is_sw   = 1'b1;
      OP_BEQ:  ctl.is_beq  = 1'b1;
      OP_HALT: ctl.is_halt = 1'b1;
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc8_core.sv
`timescale 1ns/1ps
module mc8_core
  import mc8_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  output logic [PC_W-1:0]     mem_addr,
  output logic                mem_we,
  output logic [XLEN-1:0]     mem_wdata,
  input  logic [XLEN-1:0]     mem_rdata,
  output logic                halted,
  output logic [PC_W-1:0]     dbg_pc,
  input  logic [RIDX_W-1:0]   dbg_reg_sel,
  output logic [XLEN-1:0]     dbg_reg_data
);
  localparam int EXT_W = XLEN - OFF_W;

  state_e               state;
  logic [PC_W-1:0]      pc_q;
  logic [INSTR_W-1:0]   ir_q;
  logic [XLEN-1:0]      alu_q;
  logic [PC_W-1:0]      mem_addr_q;
  logic                 mem_we_q;
  logic [XLEN-1:0]      mem_wdata_q;
  logic                 halted_q;
  logic [XLEN-1:0]      dbg_q;

  logic [RIDX_W-1:0]    idx_a, idx_b, idx_d;
  logic [OFF_W-1:0]     offset;
  ctl_t                 ctl;

  logic [XLEN-1:0]      val_a, val_b, val_dbg;
  logic [XLEN-1:0]      off_x, alu_b, alu_y;
  logic                 alu_eq;
  logic                 rf_we;
  logic [RIDX_W-1:0]    rf_wa;
  logic [XLEN-1:0]      rf_wd;
  logic [PC_W-1:0]      pc_inc, pc_br, pc_nxt;
  logic                 unused_hi;

  assign unused_hi = ^mem_rdata[XLEN-1:INSTR_W];

  mc8_decode u_dec (
    .word   (ir_q),
    .idx_a  (idx_a),
    .idx_b  (idx_b),
    .idx_d  (idx_d),
    .offset (offset),
    .ctl    (ctl)
  );

  assign rf_we = (state == ST_WB);
  assign rf_wa = ctl.is_lw ? idx_b : idx_d;
  assign rf_wd = ctl.is_lw ? mem_rdata : alu_q;

  mc8_regfile #(.W(XLEN), .AW(RIDX_W)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (rf_wa),
    .wd  (rf_wd),
    .ra1 (idx_a),
    .rd1 (val_a),
    .ra2 (idx_b),
    .rd2 (val_b),
    .ra3 (dbg_reg_sel),
    .rd3 (val_dbg)
  );

  assign off_x = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign alu_b = (ctl.is_lw || ctl.is_sw) ? off_x : val_b;

  mc8_alu #(.W(XLEN)) u_alu (
    .opa      (val_a),
    .opb      (alu_b),
    .nand_sel (ctl.alu_nand),
    .res      (alu_y),
    .same     (alu_eq)
  );

  assign pc_inc = pc_q + PC_W'(1);
  assign pc_br  = pc_inc + off_x[PC_W-1:0];
  assign pc_nxt = (ctl.is_beq && alu_eq) ? pc_br : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FETCH;
      pc_q        <= '0;
      ir_q        <= '0;
      alu_q       <= '0;
      mem_addr_q  <= '0;
      mem_we_q    <= 1'b0;
      mem_wdata_q <= '0;
      halted_q    <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          ir_q  <= mem_rdata[INSTR_W-1:0];
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          alu_q <= alu_y;
          if (ctl.is_halt) begin
            halted_q <= 1'b1;
            state    <= ST_HALT;
          end else if (ctl.is_lw || ctl.is_sw) begin
            mem_addr_q  <= alu_y[PC_W-1:0];
            mem_we_q    <= ctl.is_sw;
            mem_wdata_q <= val_b;
            state       <= ST_MEM;
          end else if (ctl.wr_rd) begin
            state <= ST_WB;
          end else begin
            pc_q       <= pc_nxt;
            mem_addr_q <= pc_nxt;
            state      <= ST_FETCH;
          end
        end
        ST_MEM: begin
          mem_we_q <= 1'b0;
          if (ctl.is_lw) begin
            state <= ST_WB;
          end else begin
            pc_q       <= pc_inc;
            mem_addr_q <= pc_inc;
            state      <= ST_FETCH;
          end
        end
        ST_WB: begin
          pc_q       <= pc_inc;
          mem_addr_q <= pc_inc;
          state      <= ST_FETCH;
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) dbg_q <= val_dbg;

  assign mem_addr     = mem_addr_q;
  assign mem_we       = mem_we_q;
  assign mem_wdata    = mem_wdata_q;
  assign halted       = halted_q;
  assign dbg_pc       = pc_q;
  assign dbg_reg_data = dbg_q;

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && $stable(pc_q)));

  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_q |=> !mem_we_q);

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |=> (pc_q == PC_W'($past(pc_q) + 1'b1)));

  // R11
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> (mem_addr_q == pc_q));

  // R9
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |-> (!rf_we && !mem_we_q));

endmodule

// File: tb/mc8_core_bench.sv
`timescale 1ns/1ps
module mc8_core_bench;
  localparam int XLEN = 32;
  localparam int PC_W = 16;
  localparam int MEMW = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst;
  logic [PC_W-1:0] mem_addr;
  logic            mem_we;
  logic [XLEN-1:0] mem_wdata;
  logic [XLEN-1:0] mem_rdata;
  logic            halted;
  logic [PC_W-1:0] dbg_pc;
  logic [2:0]      dbg_sel;
  logic [XLEN-1:0] dbg_data;

  mc8_core #(.XLEN(XLEN), .PC_W(PC_W)) u_mc8_core (
    .clk          (clk),
    .rst          (rst),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .halted       (halted),
    .dbg_pc       (dbg_pc),
    .dbg_reg_sel  (dbg_sel),
    .dbg_reg_data (dbg_data)
  );

  logic [XLEN-1:0] mem [MEMW];
  logic            ld_en;
  logic [5:0]      ld_addr;
  logic [XLEN-1:0] ld_data;
  logic            cnt_clr;
  int              we_cnt;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[5:0]];
    if (cnt_clr) we_cnt <= 0;
    else if (mem_we) we_cnt <= we_cnt + 1;
  end

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [XLEN-1:0] prog [16];
  int  plen;

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] enc(int op, int a, int b, int low);
    return {7'b0, op[2:0], a[2:0], b[2:0], low[15:0]};
  endfunction

  task automatic poke(int addr, logic [XLEN-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = addr[5:0]; ld_data = d;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic load_and_run();
    rst = 1'b1;
    cnt_clr = 1'b1;
    for (int i = 0; i < MEMW; i++) poke(i, '0);
    for (int i = 0; i < plen; i++) poke(i, prog[i]);
    @(negedge clk);
    rst = 1'b0;
    cnt_clr = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    check("run reaches halt", {31'b0, halted}, 32'd1);
  endtask

  task automatic read_reg(int idx, output logic [XLEN-1:0] v);
    @(negedge clk);
    dbg_sel = idx[2:0];
    @(negedge clk);
    v = dbg_data;
  endtask

  // R2 R3 R5 R7 R10: countdown loop with a backward branch
  task automatic t_countdown();
    logic [XLEN-1:0] v;
    prog[0] = enc(2, 0, 1, 7);
    prog[1] = enc(2, 1, 2, 3);
    prog[2] = enc(0, 1, 2, 1);
    prog[3] = enc(4, 0, 1, 2);
    prog[4] = enc(4, 0, 0, -3);
    prog[5] = enc(7, 0, 0, 0);
    prog[6] = enc(6, 0, 0, 0);
    prog[7] = 32'd5;
    prog[8] = 32'hFFFF_FFFF;
    prog[9] = 32'd2;
    plen = 10;
    load_and_run();
    read_reg(1, v); check("R7 countdown reg1", v, 32'd0);
    read_reg(2, v); check("R5 countdown reg2", v, 32'hFFFF_FFFF);
    check("R10 countdown pc at halt", {16'b0, dbg_pc}, 32'd6);
  endtask

  // R3 R4 R2: wrap-around add with unused bits set, and nand
  task automatic t_alu();
    logic [XLEN-1:0] v;
    prog[0] = enc(2, 0, 1, 5);
    prog[1] = enc(2, 0, 2, 6);
    prog[2] = enc(0, 1, 2, 16'hFFF8 | 3);
    prog[3] = enc(1, 1, 2, 4);
    prog[4] = enc(6, 0, 0, 0);
    prog[5] = 32'hFFFF_FFFF;
    prog[6] = 32'h0000_0002;
    plen = 7;
    load_and_run();
    read_reg(3, v); check("R3 add wraps", v, 32'h0000_0001);
    read_reg(4, v); check("R4 nand", v, 32'hFFFF_FFFD);
    read_reg(0, v); check("R2 reg0 untouched", v, 32'd0);
  endtask

  // R6 R5: stores with positive and negative offsets, load back
  task automatic t_store();
    logic [XLEN-1:0] v;
    prog[0] = enc(2, 0, 1, 6);
    prog[1] = enc(2, 0, 2, 7);
    prog[2] = enc(3, 2, 1, 5);
    prog[3] = enc(3, 2, 1, -1);
    prog[4] = enc(2, 2, 3, 5);
    prog[5] = enc(6, 0, 0, 0);
    prog[6] = 32'h1234_5678;
    prog[7] = 32'd10;
    plen = 8;
    load_and_run();
    check("R6 store +offset", mem[15], 32'h1234_5678);
    check("R6 store -offset", mem[9], 32'h1234_5678);
    check("R6 one strobe per store", we_cnt, 32'd2);
    read_reg(3, v); check("R5 load back", v, 32'h1234_5678);
  endtask

  // R7: not-taken then taken forward branch
  task automatic t_branch();
    logic [XLEN-1:0] v;
    prog[0] = enc(2, 0, 1, 7);
    prog[1] = enc(2, 0, 2, 8);
    prog[2] = enc(4, 1, 2, 1);
    prog[3] = enc(0, 1, 1, 3);
    prog[4] = enc(4, 1, 1, 1);
    prog[5] = enc(0, 1, 2, 4);
    prog[6] = enc(6, 0, 0, 0);
    prog[7] = 32'd3;
    prog[8] = 32'd4;
    plen = 9;
    load_and_run();
    read_reg(3, v); check("R7 not-taken falls through", v, 32'd6);
    read_reg(4, v); check("R7 taken skips", v, 32'd0);
    check("R7 pc at halt", {16'b0, dbg_pc}, 32'd6);
  endtask

  // R8 R2: noop and opcode 5 with every free bit set
  task automatic t_noop();
    logic [XLEN-1:0] v;
    prog[0] = enc(2, 0, 1, 4);
    prog[1] = {7'b0, 3'd7, 22'h3F_FFFF};
    prog[2] = {7'b0, 3'd5, 22'h3F_FFFF};
    prog[3] = {7'b0, 3'd6, 22'h3F_FFFF};
    prog[4] = 32'hA5A5_A5A5;
    plen = 5;
    load_and_run();
    read_reg(1, v); check("R8 reg1 kept", v, 32'hA5A5_A5A5);
    read_reg(7, v); check("R8 reg7 unwritten", v, 32'd0);
    check("R8 no memory write", we_cnt, 32'd0);
    check("R8 memory word kept", mem[63], 32'd0);
    check("R8 pc at halt", {16'b0, dbg_pc}, 32'd3);
  endtask

  // R9 R1: freeze after halt, then reset clears state
  task automatic t_halt_reset();
    logic [XLEN-1:0] v;
    prog[0] = enc(2, 0, 1, 3);
    prog[1] = enc(6, 0, 0, 0);
    prog[2] = enc(0, 1, 1, 1);
    prog[3] = 32'd9;
    plen = 4;
    load_and_run();
    repeat (20) @(negedge clk);
    check("R9 halted held", {31'b0, halted}, 32'd1);
    check("R9 pc frozen", {16'b0, dbg_pc}, 32'd1);
    read_reg(1, v); check("R9 reg frozen", v, 32'd9);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 pc reset", {16'b0, dbg_pc}, 32'd0);
    check("R1 halted reset", {31'b0, halted}, 32'd0);
    check("R1 we reset", {31'b0, mem_we}, 32'd0);
    read_reg(1, v); check("R1 reg cleared", v, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    cnt_clr = 1'b1; dbg_sel = '0;
    repeat (3) @(negedge clk);
    t_countdown();
    t_alu();
    t_store();
    t_branch();
    t_noop();
    t_halt_reset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule